// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block sits between a priority resolver and a register decoder in a multi-CPU interrupt controller. For each CPU it holds the running interrupt ID and its running priority. On an acknowledge request from a CPU it accepts the resolver's best pending ID for that CPU when that ID's priority beats the running priority. It records which ID was preempted, asks the pending store to clear the accepted ID, and makes it the running one. On an end-of-interrupt request it retires an ID and re-pends a level source that is still asserted.

Preempted interrupts are kept as a per-CPU linked chain stored in a link table, with one entry per (interrupt, CPU) pair. Completing the running ID pops back to the ID it preempted. Completing an ID deeper in the chain splices that ID out, so the chain is walked one link per clock. While the walk runs, `busy` is high and requests are dropped; the requester holds off until `busy` falls.

The controller has two states. `ST_IDLE` serves one acknowledge or completion per cycle. A completion that names a real ID other than the running one moves it to `ST_WALK`. `ST_WALK` advances one link per cycle while neither the target nor the chain end is seen. It returns to `ST_IDLE` on a hit, after splicing, or on reaching the end marker 1023 (not found).

Top module: `irq_ack_tracker`

## Requirements
- R1: An acknowledge whose pending ID is 1023, lies outside the implemented range, or has a priority not strictly below the CPU's running priority returns ID 1023 one cycle later (`ack_valid` high). It issues no pending-clear and changes no running state.
- R2: A granted acknowledge returns the pending ID one cycle later, makes it the CPU's running ID, and stores the previously running ID as that ID's link for this CPU.
- R3: A granted acknowledge pulses `pclr_valid` with `pclr_id` equal to the granted ID. `pclr_mask` (bit i = CPU i) has all bits set when the source's `src_one_of_n` bit is 1, and only the requesting CPU's bit otherwise. This holds for edge and level sources alike.
- R4: Running priority is the priority of the running ID (`prio_flat` bits [id*PRIO_W +: PRIO_W]), or 0x100 when the running ID is 1023. After reset every CPU runs ID 1023 at priority 0x100.
- R5: A completion takes its ID from `req_data` bits 9:0 and ignores the upper bits. It is ignored entirely (no state change, no re-pend) when the CPU's running ID is 1023.
- R6: Completing the running ID makes its link entry the new running ID, with that ID's priority, one cycle later.
- R7: Completing a real ID whose source is level-triggered (`src_edge`=0), enabled, still asserted (`src_level`=1) and targets this CPU (`src_target` bit [id*NUM_CPU+cpu]) pulses `pset_valid` one cycle later, with that ID and only this CPU's mask bit. Otherwise there is no pulse.
- R8: Completing an ID in the middle of the chain replaces the link that pointed at it with the completed ID's own link. The running ID is unchanged.
- R9: A completed ID that is not found before the walk reaches 1023 leaves the chain and the running ID unchanged.
- R10: The walk takes one clock per link visited, with `busy` high in each walk cycle. A request presented while `busy` is high produces no acknowledge, pending-clear or re-pend, and changes no running state.
- R11: Each CPU's running ID, running priority and chain are independent of the other CPUs'.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_is_eoi | input | 1 | 1 = completion, 0 = acknowledge |
| req_cpu | input | CPU_W | Requesting CPU |
| req_data | input | 32 | Completion value, ID in bits 9:0 |
| pend_id_flat | input | NUM_CPU*10 | Resolver's best pending ID per CPU |
| prio_flat | input | NUM_IRQ*PRIO_W | Priority per interrupt |
| src_one_of_n | input | NUM_IRQ | 1 = acknowledge clears pending for all CPUs |
| src_edge | input | NUM_IRQ | 1 = edge-triggered source |
| src_enabled | input | NUM_IRQ | Source enable |
| src_level | input | NUM_IRQ | Current line level |
| src_target | input | NUM_IRQ*NUM_CPU | Target CPU bits per source |
| busy | output | 1 | Chain walk in progress |
| ack_valid | output | 1 | Acknowledge result strobe |
| ack_id | output | 10 | Acknowledged ID or 1023 |
| pclr_valid | output | 1 | Pending-clear strobe |
| pclr_id | output | 10 | ID to clear |
| pclr_mask | output | NUM_CPU | CPUs to clear |
| pset_valid | output | 1 | Re-pend strobe |
| pset_id | output | 10 | ID to re-pend |
| pset_mask | output | NUM_CPU | CPU to re-pend |
| run_id_flat | output | NUM_CPU*10 | Running ID per CPU |
| run_prio_flat | output | NUM_CPU*9 | Running priority per CPU |

## Verification
Acknowledges are tried with no pending ID, with an equal and a worse priority, and with a better one. These separate the refusal path from the grant path, and the strict comparison from a non-strict one. Completions are tried on the running ID, on an ID deeper in a three-deep chain, on an ID absent from the chain, and on an idle CPU. The follow-up completions expose whether a pop, a splice or a no-op happened, and the number of busy cycles shows the walk length. Source configurations of edge, level, one-of-N and the second CPU separate the pending-clear masks, the re-pend condition and the per-CPU isolation.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    localparam int ID_W = 10;
    localparam int RP_W = 9;
    localparam logic [ID_W-1:0] ID_NONE = 10'd1023;
    localparam logic [RP_W-1:0] RP_IDLE = 9'h100;

    typedef enum logic {
        ST_IDLE,
        ST_WALK
    } walk_state_e;
endpackage

// File: rtl/irq_link_table.sv
module irq_link_table
    import irq_ack_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IRQ_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] ra_id,
    input  logic [CPU_W-1:0] ra_cpu,
    output logic [ID_W-1:0] ra_data,
    input  logic [ID_W-1:0] rb_id,
    input  logic [CPU_W-1:0] rb_cpu,
    output logic [ID_W-1:0] rb_data,
    input  logic            we,
    input  logic [ID_W-1:0] w_id,
    input  logic [CPU_W-1:0] w_cpu,
    input  logic [ID_W-1:0] w_data
);
    logic [ID_W-1:0] links [NUM_IRQ][NUM_CPU];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                for (int c = 0; c < NUM_CPU; c++) begin
                    links[i][c] <= ID_NONE;
                end
            end
        end else if (we && (w_id < ID_W'(NUM_IRQ))) begin
            links[w_id[IRQ_W-1:0]][w_cpu] <= w_data;
        end
    end

    // Entries outside the implemented range read as the chain end.
    assign ra_data = (ra_id < ID_W'(NUM_IRQ)) ? links[ra_id[IRQ_W-1:0]][ra_cpu] : ID_NONE;
    assign rb_data = (rb_id < ID_W'(NUM_IRQ)) ? links[rb_id[IRQ_W-1:0]][rb_cpu] : ID_NONE;
endmodule

// File: rtl/irq_prio_lookup.sv
module irq_prio_lookup
    import irq_ack_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W = 8,
    localparam int IRQ_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [ID_W-1:0]           id,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic [RP_W-1:0]           rprio
);
    always_comb begin
        if (id < ID_W'(NUM_IRQ)) begin
            rprio = RP_W'(prio_flat[int'(id[IRQ_W-1:0])*PRIO_W +: PRIO_W]);
        end else begin
            rprio = RP_IDLE;
        end
    end
endmodule

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker
    import irq_ack_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    parameter int PRIO_W = 8,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IRQ_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_is_eoi,
    input  logic [CPU_W-1:0]          req_cpu,
    input  logic [31:0]               req_data,
    input  logic [NUM_CPU*ID_W-1:0]   pend_id_flat,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    input  logic [NUM_IRQ-1:0]        src_one_of_n,
    input  logic [NUM_IRQ-1:0]        src_edge,
    input  logic [NUM_IRQ-1:0]        src_enabled,
    input  logic [NUM_IRQ-1:0]        src_level,
    input  logic [NUM_IRQ*NUM_CPU-1:0] src_target,
    output logic                      busy,
    output logic                      ack_valid,
    output logic [ID_W-1:0]           ack_id,
    output logic                      pclr_valid,
    output logic [ID_W-1:0]           pclr_id,
    output logic [NUM_CPU-1:0]        pclr_mask,
    output logic                      pset_valid,
    output logic [ID_W-1:0]           pset_id,
    output logic [NUM_CPU-1:0]        pset_mask,
    output logic [NUM_CPU*ID_W-1:0]   run_id_flat,
    output logic [NUM_CPU*RP_W-1:0]   run_prio_flat
);
    walk_state_e state_q, state_d;

    logic [ID_W-1:0]  run_id_q   [NUM_CPU];
    logic [RP_W-1:0]  run_prio_q [NUM_CPU];
    logic [ID_W-1:0]  walk_cur_q, walk_tgt_q;
    logic [CPU_W-1:0] walk_cpu_q;

    logic [ID_W-1:0]    cur_run, cand, eoi_id;
    logic [RP_W-1:0]    cur_rprio, cand_rp, pop_rp;
    logic               cand_in, eoi_in;
    logic               idle_req, do_ack, ack_grant, do_eoi, eoi_pop, eoi_walk, repend;
    logic [ID_W-1:0]    lb_id, la_data, lb_data;
    logic [CPU_W-1:0]   lb_cpu;
    logic               link_we;
    logic [ID_W-1:0]    lw_id, lw_data;
    logic [CPU_W-1:0]   lw_cpu;
    logic               walk_end, walk_hit;
    logic [NUM_CPU-1:0] self_bit;
    logic               unused_hi;

    assign unused_hi = ^req_data[31:ID_W];

    // Request decode
    assign cur_run   = run_id_q[req_cpu];
    assign cur_rprio = run_prio_q[req_cpu];
    assign cand      = pend_id_flat[int'(req_cpu)*ID_W +: ID_W];
    assign eoi_id    = req_data[ID_W-1:0];
    assign cand_in   = cand < ID_W'(NUM_IRQ);
    assign eoi_in    = eoi_id < ID_W'(NUM_IRQ);
    assign self_bit  = NUM_CPU'(1) << req_cpu;

    assign idle_req  = (state_q == ST_IDLE) && req_valid;
    assign do_ack    = idle_req && !req_is_eoi;
    assign ack_grant = do_ack && cand_in && (cand_rp < cur_rprio);
    assign do_eoi    = idle_req && req_is_eoi && (cur_run != ID_NONE);
    assign eoi_pop   = do_eoi && (eoi_id == cur_run);
    assign eoi_walk  = do_eoi && (eoi_id != cur_run);
    assign repend    = do_eoi && eoi_in
                     && !src_edge[eoi_id[IRQ_W-1:0]]
                     && src_enabled[eoi_id[IRQ_W-1:0]]
                     && src_level[eoi_id[IRQ_W-1:0]]
                     && src_target[int'(eoi_id[IRQ_W-1:0])*NUM_CPU + int'(req_cpu)];

    // Walk step decode: lb_data is the link of the current cursor
    assign walk_end = (lb_data == ID_NONE);
    assign walk_hit = !walk_end && (lb_data == walk_tgt_q);

    irq_link_table #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_links (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_id  (walk_tgt_q),
        .ra_cpu (walk_cpu_q),
        .ra_data(la_data),
        .rb_id  (lb_id),
        .rb_cpu (lb_cpu),
        .rb_data(lb_data),
        .we     (link_we),
        .w_id   (lw_id),
        .w_cpu  (lw_cpu),
        .w_data (lw_data)
    );

    irq_prio_lookup #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_cand_prio (
        .id       (cand),
        .prio_flat(prio_flat),
        .rprio    (cand_rp)
    );

    irq_prio_lookup #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_pop_prio (
        .id       (lb_data),
        .prio_flat(prio_flat),
        .rprio    (pop_rp)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (eoi_walk) state_d = ST_WALK;
            ST_WALK: if (walk_end || walk_hit) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Per-state control of the link table ports
    always_comb begin
        lb_id   = cur_run;
        lb_cpu  = req_cpu;
        link_we = 1'b0;
        lw_id   = cand;
        lw_cpu  = req_cpu;
        lw_data = cur_run;
        busy    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                link_we = ack_grant;
            end
            ST_WALK: begin
                busy    = 1'b1;
                lb_id   = walk_cur_q;
                lb_cpu  = walk_cpu_q;
                link_we = walk_hit;
                lw_id   = walk_cur_q;
                lw_cpu  = walk_cpu_q;
                lw_data = la_data;
            end
            default: ;
        endcase
    end

    // Running state, walk cursor and result strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                run_id_q[c]   <= ID_NONE;
                run_prio_q[c] <= RP_IDLE;
            end
            walk_cur_q <= ID_NONE;
            walk_tgt_q <= ID_NONE;
            walk_cpu_q <= '0;
            ack_valid  <= 1'b0;
            ack_id     <= ID_NONE;
            pclr_valid <= 1'b0;
            pclr_id    <= ID_NONE;
            pclr_mask  <= '0;
            pset_valid <= 1'b0;
            pset_id    <= ID_NONE;
            pset_mask  <= '0;
        end else begin
            ack_valid  <= do_ack;
            ack_id     <= ack_grant ? cand : ID_NONE;
            pclr_valid <= ack_grant;
            pclr_id    <= cand;
            pclr_mask  <= src_one_of_n[cand[IRQ_W-1:0]] ? {NUM_CPU{1'b1}} : self_bit;
            pset_valid <= repend;
            pset_id    <= eoi_id;
            pset_mask  <= self_bit;
            if (ack_grant) begin
                run_id_q[req_cpu]   <= cand;
                run_prio_q[req_cpu] <= cand_rp;
            end
            if (eoi_pop) begin
                run_id_q[req_cpu]   <= lb_data;
                run_prio_q[req_cpu] <= pop_rp;
            end
            if (eoi_walk) begin
                walk_cur_q <= cur_run;
                walk_tgt_q <= eoi_id;
                walk_cpu_q <= req_cpu;
            end else if ((state_q == ST_WALK) && !walk_end && !walk_hit) begin
                walk_cur_q <= lb_data;
            end
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_flat
        assign run_id_flat[c*ID_W +: ID_W]   = run_id_q[c];
        assign run_prio_flat[c*RP_W +: RP_W] = run_prio_q[c];
    end
endmodule

// File: rtl/irq_ack_tracker_chk.sv
module irq_ack_tracker_chk
    import irq_ack_pkg::*;
#(
    parameter int NUM_CPU = 2,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [CPU_W-1:0]        req_cpu,
    input logic                    busy,
    input logic                    ack_valid,
    input logic [ID_W-1:0]         ack_id,
    input logic                    pclr_valid,
    input logic [ID_W-1:0]         pclr_id,
    input logic [NUM_CPU-1:0]      pclr_mask,
    input logic                    pset_valid,
    input logic [NUM_CPU-1:0]      pset_mask,
    input logic [NUM_CPU*ID_W-1:0] run_id_flat,
    input logic [NUM_CPU*RP_W-1:0] run_prio_flat
);
    logic [CPU_W-1:0]   prev_cpu;
    logic [NUM_CPU-1:0] prev_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_cpu <= '0;
        else        prev_cpu <= req_cpu;
    end
    assign prev_bit = NUM_CPU'(1) << prev_cpu;

    assert_busy_drops_requests_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!ack_valid && !pclr_valid && !pset_valid));

    assert_refusal_keeps_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id == ID_NONE) |-> (!pclr_valid && $stable(run_id_flat)));

    assert_grant_becomes_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id != ID_NONE) |-> (run_id_flat[int'(prev_cpu)*ID_W +: ID_W] == ack_id));

    assert_grant_clears_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id != ID_NONE) |->
            (pclr_valid && pclr_id == ack_id && (pclr_mask == {NUM_CPU{1'b1}} || pclr_mask == prev_bit)));

    assert_repend_single_cpu_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pset_valid |-> ($onehot(pset_mask) && pset_mask == prev_bit));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assert_idle_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (run_id_flat[c*ID_W +: ID_W] == ID_NONE) == (run_prio_flat[c*RP_W +: RP_W] == RP_IDLE));
    end
endmodule

bind irq_ack_tracker irq_ack_tracker_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_cpu      (req_cpu),
    .busy         (busy),
    .ack_valid    (ack_valid),
    .ack_id       (ack_id),
    .pclr_valid   (pclr_valid),
    .pclr_id      (pclr_id),
    .pclr_mask    (pclr_mask),
    .pset_valid   (pset_valid),
    .pset_mask    (pset_mask),
    .run_id_flat  (run_id_flat),
    .run_prio_flat(run_prio_flat)
);

// File: tb/irq_ack_tracker_bench.sv
`timescale 1ns/1ps
module irq_ack_tracker_bench;
    localparam int NI = 64;
    localparam int NC = 2;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_is_eoi = 1'b0;
    logic [0:0] req_cpu = '0;
    logic [31:0] req_data = '0;
    logic [NC*10-1:0] pend_id_flat;
    logic [NI*PW-1:0] prio_flat;
    logic [NI-1:0] src_one_of_n, src_edge, src_enabled, src_level;
    logic [NI*NC-1:0] src_target;
    logic busy, ack_valid, pclr_valid, pset_valid;
    logic [9:0] ack_id, pclr_id, pset_id;
    logic [NC-1:0] pclr_mask, pset_mask;
    logic [NC*10-1:0] run_id_flat;
    logic [NC*9-1:0] run_prio_flat;

    int n_cmp = 0;
    int n_bad = 0;
    int walk_n;
    logic c_ack_valid, c_pclr_valid, c_pset_valid, c_busy;
    logic [9:0] c_ack_id, c_pclr_id, c_pset_id;
    logic [NC-1:0] c_pclr_mask, c_pset_mask;

    always #2 clk = ~clk;

    irq_ack_tracker #(.NUM_IRQ(NI), .NUM_CPU(NC), .PRIO_W(PW)) u_irq_ack_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_eoi(req_is_eoi),
        .req_cpu(req_cpu), .req_data(req_data), .pend_id_flat(pend_id_flat),
        .prio_flat(prio_flat), .src_one_of_n(src_one_of_n), .src_edge(src_edge),
        .src_enabled(src_enabled), .src_level(src_level), .src_target(src_target),
        .busy(busy), .ack_valid(ack_valid), .ack_id(ack_id), .pclr_valid(pclr_valid),
        .pclr_id(pclr_id), .pclr_mask(pclr_mask), .pset_valid(pset_valid),
        .pset_id(pset_id), .pset_mask(pset_mask), .run_id_flat(run_id_flat),
        .run_prio_flat(run_prio_flat)
    );

    function automatic int run_of(int cpu);
        return int'(run_id_flat[cpu*10 +: 10]);
    endfunction
    function automatic int rp_of(int cpu);
        return int'(run_prio_flat[cpu*9 +: 9]);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_pend(int cpu, int id);
        pend_id_flat[cpu*10 +: 10] = 10'(id);
    endtask
    task automatic set_prio(int id, int p);
        prio_flat[id*PW +: PW] = PW'(p);
    endtask

    // Present one request, capture the strobes one cycle later, wait out a walk
    task automatic issue(input logic is_eoi, input int cpu, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_is_eoi = is_eoi; req_cpu = 1'(cpu); req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        c_ack_valid = ack_valid; c_ack_id = ack_id;
        c_pclr_valid = pclr_valid; c_pclr_id = pclr_id; c_pclr_mask = pclr_mask;
        c_pset_valid = pset_valid; c_pset_id = pset_id; c_pset_mask = pset_mask;
        c_busy = busy;
        walk_n = 0;
        while (busy && walk_n < 200) begin
            @(negedge clk);
            walk_n++;
        end
    endtask

    task automatic do_ack(int cpu, int id);
        set_pend(cpu, id);
        issue(1'b0, cpu, 32'd0);
    endtask

    task automatic t_reset;
        chk("R4 reset run id cpu0", run_of(0), 1023);
        chk("R4 reset run id cpu1", run_of(1), 1023);
        chk("R4 reset run prio cpu0", rp_of(0), 256);
        chk("R10 reset busy", int'(busy), 0);
    endtask

    task automatic t_refuse_none;
        do_ack(0, 1023);
        chk("R1 ack strobe", int'(c_ack_valid), 1);
        chk("R1 ack id none", int'(c_ack_id), 1023);
        chk("R1 no pclr", int'(c_pclr_valid), 0);
        chk("R1 run unchanged", run_of(0), 1023);
    endtask

    task automatic t_grant;
        set_prio(40, 8'h80);
        do_ack(0, 40);
        chk("R2 ack id", int'(c_ack_id), 40);
        chk("R2 running id", run_of(0), 40);
        chk("R4 running prio", rp_of(0), 8'h80);
        chk("R3 pclr valid", int'(c_pclr_valid), 1);
        chk("R3 pclr id", int'(c_pclr_id), 40);
        chk("R3 pclr own cpu", int'(c_pclr_mask), 1);
    endtask

    task automatic t_refuse_prio;
        set_prio(41, 8'h80);
        do_ack(0, 41);
        chk("R1 equal prio refused", int'(c_ack_id), 1023);
        chk("R1 equal prio run kept", run_of(0), 40);
        set_prio(41, 8'h90);
        do_ack(0, 41);
        chk("R1 worse prio refused", int'(c_ack_id), 1023);
        chk("R1 worse prio no pclr", int'(c_pclr_valid), 0);
    endtask

    task automatic t_eoi_idle;
        src_edge[42] = 1'b0; src_level[42] = 1'b1;
        issue(1'b1, 1, 32'd42);
        chk("R5 idle eoi no repend", int'(c_pset_valid), 0);
        chk("R5 idle eoi run kept", run_of(1), 1023);
        chk("R5 idle eoi prio kept", rp_of(1), 256);
    endtask

    task automatic t_one_of_n;
        src_one_of_n[42] = 1'b1;
        set_prio(42, 8'h30);
        do_ack(1, 42);
        chk("R3 one-of-N mask all", int'(c_pclr_mask), 3);
        chk("R11 cpu1 runs 42", run_of(1), 42);
        chk("R11 cpu0 still 40", run_of(0), 40);
        chk("R11 cpu0 prio kept", rp_of(0), 8'h80);
    endtask

    task automatic t_nest_pop;
        set_prio(43, 8'h40);
        do_ack(0, 43);
        chk("R2 preempt run", run_of(0), 43);
        issue(1'b1, 0, 32'hFFFF_FC00 | 32'd43);
        chk("R5 upper bits ignored, R6 pop", run_of(0), 40);
        chk("R6 pop prio", rp_of(0), 8'h80);
        chk("R7 edge no repend", int'(c_pset_valid), 0);
        src_edge[40] = 1'b0; src_level[40] = 1'b1;
        issue(1'b1, 0, 32'd40);
        chk("R7 level repend", int'(c_pset_valid), 1);
        chk("R7 repend id", int'(c_pset_id), 40);
        chk("R7 repend mask", int'(c_pset_mask), 1);
        chk("R6 pop to idle", run_of(0), 1023);
        chk("R4 idle prio", rp_of(0), 256);
        issue(1'b1, 1, 32'd42);
        chk("R7 repend cpu1 mask", int'(c_pset_mask), 2);
        chk("R11 cpu1 popped", run_of(1), 1023);
        src_level[40] = 1'b0;
        src_edge[40] = 1'b1;
    endtask

    task automatic build_chain;
        set_prio(10, 8'h80); set_prio(11, 8'h40); set_prio(12, 8'h20);
        do_ack(0, 10); do_ack(0, 11); do_ack(0, 12);
        chk("R2 chain top", run_of(0), 12);
    endtask

    task automatic t_splice;
        build_chain();
        set_prio(13, 8'h01);
        set_pend(0, 13);
        @(negedge clk);
        req_valid = 1'b1; req_is_eoi = 1'b1; req_cpu = 1'b0; req_data = 32'd11;
        @(negedge clk);
        chk("R10 busy during walk", int'(busy), 1);
        req_is_eoi = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 ack dropped while busy", int'(ack_valid), 0);
        chk("R10 walk of one link done", int'(busy), 0);
        chk("R8 running kept after splice", run_of(0), 12);
        issue(1'b1, 0, 32'd12);
        chk("R8 pop skips spliced id", run_of(0), 10);
        chk("R8 prio after skip", rp_of(0), 8'h80);
        issue(1'b1, 0, 32'd10);
        chk("R8 chain empty", run_of(0), 1023);
    endtask

    task automatic t_not_found;
        build_chain();
        issue(1'b1, 0, 32'd50);
        chk("R10 walk length three", walk_n, 3);
        chk("R9 running kept", run_of(0), 12);
        issue(1'b1, 0, 32'd12);
        chk("R9 chain intact 12->11", run_of(0), 11);
        issue(1'b1, 0, 32'd11);
        chk("R9 chain intact 11->10", run_of(0), 10);
        issue(1'b1, 0, 32'd10);
        chk("R9 chain end", run_of(0), 1023);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        pend_id_flat = {NC{10'd1023}};
        prio_flat    = {NI*PW{1'b1}};
        src_one_of_n = '0;
        src_edge     = '1;
        src_enabled  = '1;
        src_level    = '0;
        src_target   = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_refuse_none();
        t_grant();
        t_refuse_prio();
        t_eoi_idle();
        t_one_of_n();
        t_nest_pop();
        t_splice();
        t_not_found();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule